// File: doc/BRIEF.md
# Four-Source Single-Level Interrupt Controller

This block sits beside a small 4-bit processor core and decides which of four interrupt causes the core services next. The causes are an asynchronous external input, which counts on its rising edge, an overflow pulse from each of two timers, and a transfer-complete pulse from the serial shift unit. Each cause has a request flag. A flag can only be raised while the matching bit of a 4-bit enable register is set. Events on a disabled cause are dropped, so they leave nothing behind.

Service is strictly single-level. When the core is idle and not in standby, the block picks the highest-priority pending flag. It then emits a one-cycle entry pulse with a fixed vector address and marks itself busy. While it is busy, new requests accumulate but are not granted. A return pulse from the core clears the flag of the cause that was granted and ends the service. After that the next pending cause can be taken. Saving and restoring the core's context is done elsewhere. The timers and the serial unit are also outside this block.

Top module: `irq4_ctrl`

## Requirements
- R1: After reset, irq_take and irq_busy are 0, irq_vec is 0, all enable bits are 0 and all request flags are clear.
- R2: Enable bit 0 gates the external cause, bit 1 timer-1, bit 2 timer-2 and bit 3 serial, with 1 meaning enabled. An event sets its flag only if the enable bit is 1 at the end of the event's cycle. A write on the same cycle counts. An event on a disabled cause is lost and is never taken after a later enable.
- R3: exti_in goes through a two-stage synchronizer and then a rising-edge detector. A rising level first sampled at clock edge k gives a grant (irq_take high) right after edge k+3 when the controller is idle. A pulse on a timer or serial event line sampled at edge k gives a grant right after edge k+1.
- R4: When several flags are pending, the order of priority is external, then timer-1, then timer-2, then serial.
- R5: The vector is 0x10 for external, 0x20 for timer-1, 0x30 for timer-2 and 0x40 for serial. It appears on irq_vec with irq_take and stays stable while irq_busy remains high.
- R6: irq_take is high for exactly one cycle per grant, and irq_busy rises together with it. No grant happens while irq_busy is high.
- R7: A reti pulse while busy clears the granted cause's flag. irq_busy falls after that edge, and the earliest next grant comes one cycle later. A reti pulse while idle has no effect.
- R8: While halt is high, no grant is issued, but flags keep being set, including by external edges. A pending request is granted on the cycle after halt falls.
- R9: tmr1_start clears the timer-1 flag and tmr2_start clears the timer-2 flag. A start pulse wins over an overflow pulse in the same cycle.
- R10: If an event for the granted cause arrives in the same cycle as reti, its flag stays set and the cause is granted again.
- R11: reti clears only the flag of the cause that was granted, even if a higher-priority flag was set during service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 4 | Enable register write value (bit 0 ext, 1 timer-1, 2 timer-2, 3 serial) |
| exti_in | input | 1 | Asynchronous external interrupt input, rising edge active |
| tmr1_ovf | input | 1 | Timer-1 overflow event pulse |
| tmr2_ovf | input | 1 | Timer-2 overflow event pulse |
| ser_done | input | 1 | Serial shift full/empty event pulse |
| tmr1_start | input | 1 | Timer-1 start command, clears the timer-1 flag |
| tmr2_start | input | 1 | Timer-2 start command, clears the timer-2 flag |
| halt | input | 1 | Core in standby; grants are held back |
| reti | input | 1 | Return-from-interrupt pulse |
| irq_take | output | 1 | One-cycle grant pulse |
| irq_vec | output | 8 | Vector address of the granted cause |
| irq_busy | output | 1 | High from grant until return |

## Verification
The bench builds the controller with its default parameters: two synchronizer stages, an 8-bit vector, and base and step both 16. That makes the four vectors exactly 0x10 to 0x40, and it fixes the external-edge latency at three edges, which the directed checks count cycle by cycle. A reference model kept in the bench follows each enable write, event, start, halt and return. This brings the same-cycle collisions within reach: enable write against event, start against overflow, and return against a fresh event. The same model also covers requests that pile up during long service or standby periods.

// File: rtl/irq4_pkg.sv
package irq4_pkg;
   localparam int unsigned IRQ_NSRC = 4;
   localparam int unsigned IRQ_IDX_W = 2;

   typedef enum logic [IRQ_IDX_W-1:0] {
      SRC_EXT  = 2'd0,
      SRC_TMR1 = 2'd1,
      SRC_TMR2 = 2'd2,
      SRC_SER  = 2'd3
   } irq_src_e;

   function automatic logic [IRQ_NSRC-1:0] src_onehot(input irq_src_e s);
      logic [IRQ_NSRC-1:0] r;
      r = '0;
      r[s] = 1'b1;
      return r;
   endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= 1'b0;
            else        chain_q[0] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign rise = chain_q[STAGES-1] & ~prev_q;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise |=> !rise); // R3
endmodule

// File: rtl/irq_req_flags.sv
module irq_req_flags #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_evt,
   input  logic [N-1:0] en_next,
   input  logic [N-1:0] start_clr,
   input  logic [N-1:0] ret_clr,
   output logic [N-1:0] flags
);
   if (N < 1) begin : g_bad_n
      $error("irq_req_flags: N must be positive");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic flag_q;
      logic flag_d;

      // start clear dominates, then a fresh enabled event, then the return clear
      always_comb begin
         flag_d = flag_q;
         if (start_clr[i])                    flag_d = 1'b0;
         else if (set_evt[i] && en_next[i])   flag_d = 1'b1;
         else if (ret_clr[i])                 flag_d = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) flag_q <= 1'b0;
         else        flag_q <= flag_d;
      end

      assign flags[i] = flag_q;

      AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
         (!en_next[i] && !flag_q) |=> !flag_q); // R2
      AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         start_clr[i] |=> !flag_q); // R9
      AST_EVENT_BEATS_RET: assert property (@(posedge clk) disable iff (!rst_n)
         (set_evt[i] && en_next[i] && !start_clr[i]) |=> flag_q); // R10
   end
endmodule

// File: rtl/irq_svc_arb.sv
module irq_svc_arb
   import irq4_pkg::*;
#(
   parameter int unsigned N        = IRQ_NSRC,
   parameter int unsigned VEC_W    = 8,
   parameter int unsigned VEC_BASE = 16,
   parameter int unsigned VEC_STEP = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     flags,
   input  logic             halt,
   input  logic             reti,
   output logic             take,
   output logic [VEC_W-1:0] vec,
   output logic             in_svc,
   output logic [N-1:0]     ret_clr
);
   localparam int unsigned VEC_TOP = VEC_BASE + (N - 1) * VEC_STEP;

   if (N != IRQ_NSRC) begin : g_bad_n
      $error("irq_svc_arb: N must match the source enumeration");
   end
   if (VEC_W > 31 || VEC_TOP >= (32'd1 << VEC_W)) begin : g_bad_vec
      $error("irq_svc_arb: vector range does not fit VEC_W");
   end

   irq_src_e         pick;
   logic             any_req;
   logic             grant;
   logic             take_q;
   logic             svc_q;
   irq_src_e         src_q;
   logic [VEC_W-1:0] vec_q;
   logic [VEC_W-1:0] pick_vec;

   // lowest index wins: scan from the bottom of the priority list upward
   always_comb begin
      pick = SRC_SER;
      for (int i = N - 1; i >= 0; i--) begin
         if (flags[i]) pick = irq_src_e'(i[IRQ_IDX_W-1:0]);
      end
   end

   assign any_req  = |flags;
   assign grant    = any_req && !svc_q && !halt;
   assign pick_vec = VEC_W'(VEC_BASE + 32'(pick) * VEC_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         take_q <= 1'b0;
         svc_q  <= 1'b0;
         src_q  <= SRC_EXT;
         vec_q  <= '0;
      end else begin
         take_q <= grant;
         if (grant) begin
            svc_q <= 1'b1;
            src_q <= pick;
            vec_q <= pick_vec;
         end else if (svc_q && reti) begin
            svc_q <= 1'b0;
         end
      end
   end

   assign ret_clr = (svc_q && reti) ? src_onehot(src_q) : '0;
   assign take    = take_q;
   assign vec     = vec_q;
   assign in_svc  = svc_q;

   AST_TAKE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      take_q |=> !take_q); // R6
   AST_TAKE_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      take_q |-> svc_q); // R6
   AST_NO_NEST: assert property (@(posedge clk) disable iff (!rst_n)
      svc_q |=> !take_q); // R6
   AST_HALT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> !take_q); // R8
   AST_RET_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_q && reti) |=> !svc_q); // R7
   AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_q && !take_q) |-> $stable(vec_q)); // R5
   AST_RET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ret_clr)); // R11
endmodule

// File: rtl/irq4_ctrl.sv
module irq4_ctrl
   import irq4_pkg::*;
#(
   parameter int unsigned VEC_W       = 8,
   parameter int unsigned VEC_BASE    = 16,
   parameter int unsigned VEC_STEP    = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_we,
   input  logic [3:0]       en_wdata,
   input  logic             exti_in,
   input  logic             tmr1_ovf,
   input  logic             tmr2_ovf,
   input  logic             ser_done,
   input  logic             tmr1_start,
   input  logic             tmr2_start,
   input  logic             halt,
   input  logic             reti,
   output logic             irq_take,
   output logic [VEC_W-1:0] irq_vec,
   output logic             irq_busy
);
   localparam int unsigned N = IRQ_NSRC;

   logic [N-1:0] en_q;
   logic [N-1:0] en_next;
   logic         ext_rise;
   logic [N-1:0] evt;
   logic [N-1:0] start_clr;
   logic [N-1:0] ret_clr;
   logic [N-1:0] flags;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_q <= '0;
      else if (en_we) en_q <= en_wdata;
   end

   // an event is judged against the enable value that holds at the end of its cycle
   assign en_next = en_we ? en_wdata : en_q;

   irq_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (exti_in),
      .rise     (ext_rise)
   );

   always_comb begin
      evt             = '0;
      evt[SRC_EXT]    = ext_rise;
      evt[SRC_TMR1]   = tmr1_ovf;
      evt[SRC_TMR2]   = tmr2_ovf;
      evt[SRC_SER]    = ser_done;
      start_clr           = '0;
      start_clr[SRC_TMR1] = tmr1_start;
      start_clr[SRC_TMR2] = tmr2_start;
   end

   irq_req_flags #(.N(N)) u_flags (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_evt   (evt),
      .en_next   (en_next),
      .start_clr (start_clr),
      .ret_clr   (ret_clr),
      .flags     (flags)
   );

   irq_svc_arb #(
      .N        (N),
      .VEC_W    (VEC_W),
      .VEC_BASE (VEC_BASE),
      .VEC_STEP (VEC_STEP)
   ) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .flags   (flags),
      .halt    (halt),
      .reti    (reti),
      .take    (irq_take),
      .vec     (irq_vec),
      .in_svc  (irq_busy),
      .ret_clr (ret_clr)
   );

   AST_FLAG_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (evt == '0) |=> ((flags & ~$past(flags)) == '0)); // R2
   AST_BUSY_DROP_ON_RET: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_busy) |-> $past(reti)); // R7
endmodule

// File: tb/test_irq4_ctrl.sv
module test_irq4_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en_we = 1'b0;
   logic [3:0] en_wdata = '0;
   logic       exti_in = 1'b0;
   logic       tmr1_ovf = 1'b0, tmr2_ovf = 1'b0, ser_done = 1'b0;
   logic       tmr1_start = 1'b0, tmr2_start = 1'b0;
   logic       halt = 1'b0, reti = 1'b0;
   logic       irq_take, irq_busy;
   logic [7:0] irq_vec;

   int total = 0;
   int bad   = 0;
   int cyc_n = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   irq4_ctrl i_irq4_ctrl (
      .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata),
      .exti_in(exti_in), .tmr1_ovf(tmr1_ovf), .tmr2_ovf(tmr2_ovf),
      .ser_done(ser_done), .tmr1_start(tmr1_start), .tmr2_start(tmr2_start),
      .halt(halt), .reti(reti), .irq_take(irq_take), .irq_vec(irq_vec),
      .irq_busy(irq_busy)
   );

   // reference model built from the requirements
   logic [3:0] m_en, m_flag;
   logic       m_s0, m_s1, m_prev, m_svc, m_take;
   logic [1:0] m_src;
   logic [7:0] m_vec;

   function automatic logic [7:0] vec_for(input logic [1:0] s);
      return 8'(16 * (int'(s) + 1));
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = '0; m_flag = '0; m_s0 = 0; m_s1 = 0; m_prev = 0;
         m_svc = 0; m_take = 0; m_src = '0; m_vec = '0;
      end else begin
         logic [3:0] en_n, ev, st, rc, nf;
         logic       g;
         logic [1:0] pk;
         en_n = en_we ? en_wdata : m_en;
         ev   = {ser_done, tmr2_ovf, tmr1_ovf, m_s1 & ~m_prev};
         st   = {1'b0, tmr2_start, tmr1_start, 1'b0};
         rc   = (reti && m_svc) ? (4'b1 << m_src) : 4'b0;
         g    = (m_flag != 0) && !m_svc && !halt;
         pk   = 2'd3;
         for (int i = 3; i >= 0; i--) if (m_flag[i]) pk = 2'(i);
         for (int i = 0; i < 4; i++) begin
            if (st[i])                nf[i] = 1'b0;
            else if (ev[i] && en_n[i]) nf[i] = 1'b1;
            else if (rc[i])           nf[i] = 1'b0;
            else                      nf[i] = m_flag[i];
         end
         m_take = g;
         if (g) begin m_svc = 1; m_src = pk; m_vec = vec_for(pk); end
         else if (reti && m_svc) m_svc = 0;
         m_flag = nf; m_en = en_n;
         m_prev = m_s1; m_s1 = m_s0; m_s0 = exti_in;
      end
   end

   task automatic expect_eq(string tag, logic [7:0] act, logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk(string tag);
      expect_eq({tag, " take"}, 8'(irq_take), 8'(m_take));
      expect_eq({tag, " busy"}, 8'(irq_busy), 8'(m_svc));
      expect_eq({tag, " vec"},  irq_vec, m_vec);
   endtask

   task automatic tick(string tag);
      @(posedge clk);
      @(negedge clk);
      en_we = 0; tmr1_ovf = 0; tmr2_ovf = 0; ser_done = 0;
      tmr1_start = 0; tmr2_start = 0; reti = 0;
      chk(tag);
   endtask

   task automatic write_en(logic [3:0] v, string tag);
      en_we = 1; en_wdata = v;
      tick(tag);
   endtask

   task automatic drain(string tag);
      for (int k = 0; k < 40; k++) begin
         if (irq_busy) reti = 1;
         tick(tag);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc_n++;
      if (cyc_n == 150000) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         finish_run();
      end
   end

   initial begin
      int seed;
      seed = 32'h1c3a5;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1 reset state
      expect_eq("R1 take", 8'(irq_take), 8'h0);
      expect_eq("R1 busy", 8'(irq_busy), 8'h0);
      expect_eq("R1 vec",  irq_vec, 8'h0);
      tick("R1");

      // R2 event on disabled cause is lost
      tmr1_ovf = 1; tick("R2");
      write_en(4'hF, "R2");
      repeat (4) tick("R2");
      expect_eq("R2 lost event", 8'(irq_busy), 8'h0);
      write_en(4'h0, "R2");
      // enable write in the same cycle as the event counts
      en_we = 1; en_wdata = 4'h2; tmr1_ovf = 1; tick("R2");
      tick("R2");
      expect_eq("R2 same-cycle enable", 8'(irq_take), 8'h1);
      expect_eq("R5 timer-1 vector", irq_vec, 8'h20);
      drain("R7");

      // R3 external edge latency: sampled at edge k, take after edge k+3
      write_en(4'h1, "R3");
      exti_in = 1;
      tick("R3"); tick("R3"); tick("R3");
      expect_eq("R3 no early take", 8'(irq_take), 8'h0);
      tick("R3");
      expect_eq("R3 take at k+3", 8'(irq_take), 8'h1);
      expect_eq("R5 ext vector", irq_vec, 8'h10);
      reti = 1; tick("R7");
      expect_eq("R7 busy ends", 8'(irq_busy), 8'h0);
      exti_in = 0;
      repeat (3) tick("R3");

      // R4 priority among simultaneous requests
      write_en(4'hF, "R4");
      tmr1_ovf = 1; tmr2_ovf = 1; ser_done = 1; tick("R4");
      tick("R4");
      expect_eq("R4 first timer-1", irq_vec, 8'h20);
      reti = 1; tick("R4"); tick("R4");
      expect_eq("R4 then timer-2", irq_vec, 8'h30);
      reti = 1; tick("R4"); tick("R4");
      expect_eq("R4 then serial", irq_vec, 8'h40);
      expect_eq("R5 serial take", 8'(irq_take), 8'h1);
      // R11 / R6: higher cause arrives during serial service
      tmr1_ovf = 1; tick("R6");
      repeat (3) tick("R6");
      expect_eq("R6 no nesting", 8'(irq_take), 8'h0);
      expect_eq("R5 vec held", irq_vec, 8'h40);
      reti = 1; tick("R11"); tick("R11");
      expect_eq("R11 timer-1 kept", irq_vec, 8'h20);
      reti = 1; tick("R11");
      repeat (3) tick("R11");
      expect_eq("R11 serial cleared", 8'(irq_busy), 8'h0);

      // R7 reti while idle ignored
      reti = 1; tick("R7");
      ser_done = 1; tick("R7"); tick("R7");
      expect_eq("R7 idle reti ignored", irq_vec, 8'h40);
      drain("R7");

      // R8 standby holds grants, latches external edge
      halt = 1;
      exti_in = 1; tmr2_ovf = 1; tick("R8");
      repeat (8) tick("R8");
      expect_eq("R8 held", 8'(irq_busy), 8'h0);
      halt = 0; tick("R8");
      expect_eq("R8 ext after standby", irq_vec, 8'h10);
      reti = 1; tick("R8"); tick("R8");
      expect_eq("R8 timer-2 next", irq_vec, 8'h30);
      // R10 event with reti on the granted cause
      reti = 1; tmr2_ovf = 1; tick("R10"); tick("R10");
      expect_eq("R10 retaken", 8'(irq_take), 8'h1);
      expect_eq("R10 vec", irq_vec, 8'h30);
      // R9 start beats overflow
      tmr1_ovf = 1; tmr1_start = 1; tick("R9");
      tmr2_ovf = 1; tick("R9");
      tmr2_start = 1; tick("R9");
      reti = 1; tick("R9");
      repeat (3) tick("R9");
      expect_eq("R9 flags cleared", 8'(irq_busy), 8'h0);
      exti_in = 0;
      drain("R9");

      // constrained random mix
      for (int n = 0; n < 6000; n++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 4) begin en_we = 1; en_wdata = 4'($urandom); end
         exti_in    = ($urandom_range(0, 9) == 0) ? ~exti_in : exti_in;
         tmr1_ovf   = ($urandom_range(0, 11) == 0);
         tmr2_ovf   = ($urandom_range(0, 11) == 0);
         ser_done   = ($urandom_range(0, 13) == 0);
         tmr1_start = ($urandom_range(0, 19) == 0);
         tmr2_start = ($urandom_range(0, 19) == 0);
         reti       = ($urandom_range(0, 3) == 0);
         if ($urandom_range(0, 39) == 0) halt = ~halt;
         tick("R4");
      end
      halt = 0;
      drain("R6");
      finish_run();
   end
endmodule